// File: doc/BRIEF.md
# Memory Protection Region Checker

This block checks every user-mode CPU access against eight programmable address ranges and a background range that covers everything no enabled range claims. Each range has an inclusive lower and upper bound on 16-byte granules, an enable bit and three permission bits. A data port checks loads and stores, and a separate fetch port checks instruction fetches. Both ports are checked in parallel every cycle.

When an access is refused, the block raises a one-cycle fault pulse on the matching port. In the same clock edge it captures a fault record for that port. The record holds a vector with one bit for each range that contained the address and the OR of those ranges' permissions. For a background fault the vector is zero and the background permissions are stored instead. A data fault also captures the full faulting address. Software programs the ranges and reads the records through a flat indexed register port: writes take effect on the clock edge, and reads are combinational.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every range is disabled, the background permissions read 3'b111, all three fault registers read zero and neither fault output is high.
- R2: A range matches an address when its enable bit is set and lower <= address <= upper, compared on address bits [31:4] only. A bound written with nonzero low 4 bits reads back with those bits cleared, and an upper bound of X covers every byte up to X|0xF.
- R3: Permission bits are bit 2 = read, bit 1 = write, bit 0 = execute. The effective permission of an address is the bitwise OR of the permissions of all matching ranges. A data read needs read, a data write needs write and a fetch needs execute.
- R4: An address with no matching enabled range takes the background permissions.
- R5: A supervisor-mode access (user flag low) never faults and never changes any fault register. A cycle with no request does the same.
- R6: A refused data access drives `d_fault_o` high for exactly the cycle after the access is sampled. At that clock edge the data record is loaded: bits [10:3] get the match vector (bit n = range n) and bits [2:0] get the effective permissions. For a background fault the vector is zero and bits [2:0] hold the background permissions.
- R7: A refused data access loads its full byte address into the data fault address register.
- R8: A refused fetch drives `i_fault_o` and loads the fetch record, which uses the same layout and rules as R6. It leaves the data fault address register unchanged.
- R9: Each record holds its value until the next fault of its own kind. A data fault and a fetch fault in the same cycle both load their own records.
- R10: Register indices: range n lower bound at 4n, upper bound at 4n+1, and control at 4n+2 (bit 3 = enable, bits 2:0 = permissions). Background permissions are at 32, the data record at 33, the data fault address at 34 and the fetch record at 35. Indices 33 to 35 are read-only, so writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_en_i | input | 1 | Register write strobe |
| cfg_wr_idx_i | input | 6 | Register write index |
| cfg_wr_data_i | input | 32 | Register write data |
| cfg_rd_idx_i | input | 6 | Register read index |
| cfg_rd_data_o | output | 32 | Register read data (combinational) |
| d_req_i | input | 1 | Data access valid |
| d_write_i | input | 1 | Data access is a store |
| d_user_i | input | 1 | Data access made in user mode |
| d_addr_i | input | 32 | Data byte address |
| i_req_i | input | 1 | Fetch valid |
| i_user_i | input | 1 | Fetch made in user mode |
| i_addr_i | input | 32 | Fetch byte address |
| d_fault_o | output | 1 | Data protection fault pulse |
| i_fault_o | output | 1 | Fetch protection fault pulse |

## Verification
The ranges are set up with two overlapping ranges that hold different rights, so an access in the overlap only passes if the permissions are ORed. A design that picked only one matching range would fault on a store that should pass, or would record a single-bit vector. Bounds are probed at the last byte of a range's upper granule and at the first byte past it. An off-by-one compare, or one that used the low address bits, would move the fault to the wrong side. One vector refuses a data access and a fetch in the same cycle and checks that each record gets its own content. Other vectors check that fetch faults, supervisor accesses, idle cycles and writes to the read-only indices leave the data address register and the records untouched.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int GRAN_BITS = 4;

    localparam int PERM_RD = 2;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 0;

    typedef logic [2:0] perm_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    function automatic perm_t need_mask(acc_kind_e kind);
        perm_t m;
        m = '0;
        case (kind)
            ACC_LOAD:  m[PERM_RD] = 1'b1;
            ACC_STORE: m[PERM_WR] = 1'b1;
            default:   m[PERM_EX] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mpu_region_cfg.sv
module mpu_region_cfg
    import mpu_pkg::*;
#(
    parameter int NR = 8,
    parameter int AW = 32,
    parameter int IW = 6,
    localparam int GW = AW - GRAN_BITS
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic [IW-1:0]          wr_idx_i,
    input  logic [AW-1:0]          wr_data_i,
    output logic [NR-1:0][GW-1:0]  lo_o,
    output logic [NR-1:0][GW-1:0]  hi_o,
    output logic [NR-1:0]          valid_o,
    output perm_t [NR-1:0]         perm_o,
    output perm_t                  bg_perm_o
);

    typedef struct packed {
        logic [NR-1:0][GW-1:0] lo;
        logic [NR-1:0][GW-1:0] hi;
        logic [NR-1:0]         valid;
        perm_t [NR-1:0]        perm;
        perm_t                 bg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int r = 0; r < NR; r++) begin
                if (wr_idx_i == IW'(4 * r))
                    cfg_d.lo[r] = wr_data_i[AW-1:GRAN_BITS];
                if (wr_idx_i == IW'(4 * r + 1))
                    cfg_d.hi[r] = wr_data_i[AW-1:GRAN_BITS];
                if (wr_idx_i == IW'(4 * r + 2)) begin
                    cfg_d.valid[r] = wr_data_i[3];
                    cfg_d.perm[r]  = wr_data_i[2:0];
                end
            end
            if (wr_idx_i == IW'(4 * NR))
                cfg_d.bg = wr_data_i[2:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q       <= '0;
            cfg_q.bg    <= 3'b111;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lo_o      = cfg_q.lo;
    assign hi_o      = cfg_q.hi;
    assign valid_o   = cfg_q.valid;
    assign perm_o    = cfg_q.perm;
    assign bg_perm_o = cfg_q.bg;

endmodule

// File: rtl/mpu_port_check.sv
module mpu_port_check
    import mpu_pkg::*;
#(
    parameter int NR = 8,
    parameter int GW = 28
) (
    input  logic [NR-1:0][GW-1:0] lo_i,
    input  logic [NR-1:0][GW-1:0] hi_i,
    input  logic [NR-1:0]         valid_i,
    input  perm_t [NR-1:0]        perm_i,
    input  perm_t                 bg_perm_i,
    input  logic [GW-1:0]         gran_i,
    input  perm_t                 need_i,
    output logic [NR-1:0]         hit_o,
    output perm_t                 perm_o,
    output logic                  deny_o
);

    for (genvar r = 0; r < NR; r++) begin : g_match
        assign hit_o[r] = valid_i[r] && (gran_i >= lo_i[r]) && (gran_i <= hi_i[r]);
    end

    perm_t perm_or;

    always_comb begin
        perm_or = '0;
        for (int r = 0; r < NR; r++) begin
            if (hit_o[r]) perm_or = perm_or | perm_i[r];
        end
        perm_o = (hit_o == '0) ? bg_perm_i : perm_or;
        deny_o = (need_i & ~perm_o) != '0;
    end

endmodule

// File: rtl/mpu_fault_rec.sv
module mpu_fault_rec
    import mpu_pkg::*;
#(
    parameter int NR = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic          user_i,
    input  logic          deny_i,
    input  logic [NR-1:0] hit_i,
    input  perm_t         perm_i,
    output logic          fault_o,
    output logic [NR-1:0] hit_o,
    output perm_t         perm_o
);

    typedef struct packed {
        logic          fault;
        logic [NR-1:0] hit;
        perm_t         perm;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d       = rec_q;
        rec_d.fault = req_i && user_i && deny_i;
        if (rec_d.fault) begin
            rec_d.hit  = hit_i;
            rec_d.perm = perm_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rec_q <= '0;
        else         rec_q <= rec_d;
    end

    assign fault_o = rec_q.fault;
    assign hit_o   = rec_q.hit;
    assign perm_o  = rec_q.perm;

    assert_sup_no_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_i || !user_i) |=> !fault_o);

    assert_record_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o |-> ($stable(hit_o) && $stable(perm_o)));

    assert_fault_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(req_i && user_i && deny_i));

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
    import mpu_pkg::*;
#(
    parameter int NR = 8,
    parameter int AW = 32,
    localparam int IW = $clog2(4 * NR + 4),
    localparam int GW = AW - GRAN_BITS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_wr_en_i,
    input  logic [IW-1:0] cfg_wr_idx_i,
    input  logic [AW-1:0] cfg_wr_data_i,
    input  logic [IW-1:0] cfg_rd_idx_i,
    output logic [AW-1:0] cfg_rd_data_o,
    input  logic          d_req_i,
    input  logic          d_write_i,
    input  logic          d_user_i,
    input  logic [AW-1:0] d_addr_i,
    input  logic          i_req_i,
    input  logic          i_user_i,
    input  logic [AW-1:0] i_addr_i,
    output logic          d_fault_o,
    output logic          i_fault_o
);

    localparam int IDX_BG   = 4 * NR;
    localparam int IDX_DREC = 4 * NR + 1;
    localparam int IDX_DADR = 4 * NR + 2;
    localparam int IDX_IREC = 4 * NR + 3;

    logic [NR-1:0][GW-1:0] lo, hi;
    logic [NR-1:0]         valid;
    perm_t [NR-1:0]        perm;
    perm_t                 bg_perm;

    mpu_region_cfg #(.NR(NR), .AW(AW), .IW(IW)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (cfg_wr_en_i),
        .wr_idx_i  (cfg_wr_idx_i),
        .wr_data_i (cfg_wr_data_i),
        .lo_o      (lo),
        .hi_o      (hi),
        .valid_o   (valid),
        .perm_o    (perm),
        .bg_perm_o (bg_perm)
    );

    logic [NR-1:0] d_hit, i_hit, d_hit_q, i_hit_q;
    perm_t         d_perm, i_perm, d_perm_q, i_perm_q;
    logic          d_deny, i_deny;
    perm_t         d_need, i_need;

    assign d_need = need_mask(d_write_i ? ACC_STORE : ACC_LOAD);
    assign i_need = need_mask(ACC_FETCH);

    logic unused_fetch_low;
    assign unused_fetch_low = ^i_addr_i[GRAN_BITS-1:0];

    mpu_port_check #(.NR(NR), .GW(GW)) u_dchk (
        .lo_i      (lo),
        .hi_i      (hi),
        .valid_i   (valid),
        .perm_i    (perm),
        .bg_perm_i (bg_perm),
        .gran_i    (d_addr_i[AW-1:GRAN_BITS]),
        .need_i    (d_need),
        .hit_o     (d_hit),
        .perm_o    (d_perm),
        .deny_o    (d_deny)
    );

    mpu_port_check #(.NR(NR), .GW(GW)) u_ichk (
        .lo_i      (lo),
        .hi_i      (hi),
        .valid_i   (valid),
        .perm_i    (perm),
        .bg_perm_i (bg_perm),
        .gran_i    (i_addr_i[AW-1:GRAN_BITS]),
        .need_i    (i_need),
        .hit_o     (i_hit),
        .perm_o    (i_perm),
        .deny_o    (i_deny)
    );

    mpu_fault_rec #(.NR(NR)) u_drec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (d_req_i),
        .user_i  (d_user_i),
        .deny_i  (d_deny),
        .hit_i   (d_hit),
        .perm_i  (d_perm),
        .fault_o (d_fault_o),
        .hit_o   (d_hit_q),
        .perm_o  (d_perm_q)
    );

    mpu_fault_rec #(.NR(NR)) u_irec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (i_req_i),
        .user_i  (i_user_i),
        .deny_i  (i_deny),
        .hit_i   (i_hit),
        .perm_i  (i_perm),
        .fault_o (i_fault_o),
        .hit_o   (i_hit_q),
        .perm_o  (i_perm_q)
    );

    typedef struct packed {
        logic [AW-1:0] daddr;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        if (d_req_i && d_user_i && d_deny) top_d.daddr = d_addr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    always_comb begin
        cfg_rd_data_o = '0;
        for (int r = 0; r < NR; r++) begin
            if (cfg_rd_idx_i == IW'(4 * r))
                cfg_rd_data_o = {lo[r], {GRAN_BITS{1'b0}}};
            if (cfg_rd_idx_i == IW'(4 * r + 1))
                cfg_rd_data_o = {hi[r], {GRAN_BITS{1'b0}}};
            if (cfg_rd_idx_i == IW'(4 * r + 2))
                cfg_rd_data_o = AW'({valid[r], perm[r]});
        end
        if (cfg_rd_idx_i == IW'(IDX_BG))   cfg_rd_data_o = AW'(bg_perm);
        if (cfg_rd_idx_i == IW'(IDX_DREC)) cfg_rd_data_o = AW'({d_hit_q, d_perm_q});
        if (cfg_rd_idx_i == IW'(IDX_DADR)) cfg_rd_data_o = top_q.daddr;
        if (cfg_rd_idx_i == IW'(IDX_IREC)) cfg_rd_data_o = AW'({i_hit_q, i_perm_q});
    end

    assert_fetch_keeps_daddr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !d_fault_o |-> $stable(top_q.daddr));

    assert_hit_only_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_fault_o |-> ((d_hit_q & ~$past(valid)) == '0));

    assert_ifault_hit_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        i_fault_o |-> ((i_hit_q & ~$past(valid)) == '0));

endmodule

// File: tb/mpu_region_check_tb.sv
module mpu_region_check_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        d_req = 1'b0, d_write = 1'b0, d_user = 1'b0;
    logic [31:0] d_addr = '0;
    logic        i_req = 1'b0, i_user = 1'b0;
    logic [31:0] i_addr = '0;
    logic        d_fault, i_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mpu_region_check u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cfg_wr_en_i   (wr_en),
        .cfg_wr_idx_i  (wr_idx),
        .cfg_wr_data_i (wr_data),
        .cfg_rd_idx_i  (rd_idx),
        .cfg_rd_data_o (rd_data),
        .d_req_i       (d_req),
        .d_write_i     (d_write),
        .d_user_i      (d_user),
        .d_addr_i      (d_addr),
        .i_req_i       (i_req),
        .i_user_i      (i_user),
        .i_addr_i      (i_addr),
        .d_fault_o     (d_fault),
        .i_fault_o     (i_fault)
    );

    typedef struct packed {
        logic        dv, dw, du;
        logic [31:0] da;
        logic        iv, iu;
        logic [31:0] ia;
        logic        edf, eif;
        logic [10:0] edrec, eirec;
        logic [31:0] edfa;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,32'h1004, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h000,11'h000, 32'h0},
        '{1'b1,1'b1,1'b1,32'h1004, 1'b0,1'b1,32'h0, 1'b1,1'b0, 11'h00C,11'h000, 32'h1004},
        '{1'b1,1'b1,1'b1,32'h1804, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h00C,11'h000, 32'h1004},
        '{1'b1,1'b0,1'b1,32'h2004, 1'b0,1'b1,32'h0, 1'b1,1'b0, 11'h012,11'h000, 32'h2004},
        '{1'b1,1'b1,1'b1,32'h3000, 1'b0,1'b1,32'h0, 1'b1,1'b0, 11'h004,11'h000, 32'h3000},
        '{1'b1,1'b0,1'b1,32'h3000, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h004,11'h000, 32'h3000},
        '{1'b1,1'b1,1'b0,32'h3000, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h004,11'h000, 32'h3000},
        '{1'b0,1'b0,1'b1,32'h0,    1'b1,1'b1,32'h4010, 1'b0,1'b0, 11'h004,11'h000, 32'h3000},
        '{1'b0,1'b0,1'b1,32'h0,    1'b1,1'b1,32'h1000, 1'b0,1'b1, 11'h004,11'h00C, 32'h3000},
        '{1'b1,1'b1,1'b1,32'h8000, 1'b1,1'b1,32'h1FFF, 1'b1,1'b1, 11'h004,11'h01E, 32'h8000},
        '{1'b1,1'b0,1'b1,32'h0FFF, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h004,11'h01E, 32'h8000},
        '{1'b0,1'b0,1'b1,32'h0,    1'b1,1'b1,32'h0FF0, 1'b0,1'b1, 11'h004,11'h004, 32'h8000},
        '{1'b0,1'b0,1'b1,32'h0,    1'b1,1'b0,32'h0FF0, 1'b0,1'b0, 11'h004,11'h004, 32'h8000},
        '{1'b1,1'b0,1'b1,32'h2800, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h004,11'h004, 32'h8000},
        '{1'b1,1'b0,1'b1,32'h27FF, 1'b0,1'b1,32'h0, 1'b1,1'b0, 11'h012,11'h004, 32'h27FF},
        '{1'b0,1'b1,1'b1,32'h3000, 1'b0,1'b1,32'h0, 1'b0,1'b0, 11'h012,11'h004, 32'h27FF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] val);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 d_fault", {31'b0, d_fault}, 32'h0);
        chk("R1 i_fault", {31'b0, i_fault}, 32'h0);
        rd(6'd32, v); chk("R1 background perms", v, 32'h7);
        rd(6'd2,  v); chk("R1 range0 control", v, 32'h0);
        rd(6'd33, v); chk("R1 data record", v, 32'h0);
        rd(6'd34, v); chk("R1 data address", v, 32'h0);
        rd(6'd35, v); chk("R1 fetch record", v, 32'h0);

        // configuration; R10 index map, R2 granule truncation
        wr(6'd0, 32'h0000_1007);
        wr(6'd1, 32'h0000_1FF0);
        wr(6'd2, 32'h0000_000C);
        wr(6'd4, 32'h0000_1800);
        wr(6'd5, 32'h0000_27F0);
        wr(6'd6, 32'h0000_000A);
        wr(6'd8, 32'h0000_4000);
        wr(6'd9, 32'h0000_4FF0);
        wr(6'd10, 32'h0000_0009);
        wr(6'd12, 32'h0000_8000);
        wr(6'd13, 32'h0000_8FF0);
        wr(6'd14, 32'h0000_0007);
        wr(6'd32, 32'h0000_0004);
        rd(6'd0, v);  chk("R2 lower bound low bits cleared", v, 32'h1000);
        rd(6'd6, v);  chk("R10 range1 control", v, 32'h0000_000A);
        rd(6'd32, v); chk("R10 background write", v, 32'h4);

        // main vector table: R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            d_req = VECS[k].dv; d_write = VECS[k].dw; d_user = VECS[k].du; d_addr = VECS[k].da;
            i_req = VECS[k].iv; i_user = VECS[k].iu; i_addr = VECS[k].ia;
            @(posedge clk);
            #1;
            d_req = 1'b0; i_req = 1'b0;
            chk($sformatf("R3/R4/R5/R6 d_fault vec %0d", k), {31'b0, d_fault}, {31'b0, VECS[k].edf});
            chk($sformatf("R3/R4/R5/R8 i_fault vec %0d", k), {31'b0, i_fault}, {31'b0, VECS[k].eif});
            rd(6'd33, v); chk($sformatf("R6/R9 data record vec %0d", k), v, {21'b0, VECS[k].edrec});
            rd(6'd35, v); chk($sformatf("R8/R9 fetch record vec %0d", k), v, {21'b0, VECS[k].eirec});
            rd(6'd34, v); chk($sformatf("R7/R8 data address vec %0d", k), v, VECS[k].edfa);
        end

        // R6: fault is a single-cycle pulse
        @(posedge clk);
        #1;
        chk("R6 pulse ends", {30'b0, d_fault, i_fault}, 32'h0);

        // R10: writes to read-only indices are ignored
        wr(6'd33, 32'hFFFF_FFFF);
        wr(6'd34, 32'hFFFF_FFFF);
        wr(6'd35, 32'hFFFF_FFFF);
        rd(6'd33, v); chk("R10 data record read-only", v, 32'h012);
        rd(6'd34, v); chk("R10 data address read-only", v, 32'h27FF);
        rd(6'd35, v); chk("R10 fetch record read-only", v, 32'h004);

        // R2: disabling a range sends its addresses to the background
        wr(6'd10, 32'h0000_0001);
        @(negedge clk);
        i_req = 1'b1; i_user = 1'b1; i_addr = 32'h4010;
        @(posedge clk);
        #1;
        i_req = 1'b0;
        chk("R2 disabled range no match", {31'b0, i_fault}, 32'h1);
        rd(6'd35, v); chk("R2/R4 background fetch record", v, 32'h004);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule